// File: doc/BRIEF.md
# Sector Erase Acceptance Window Timer

This block models the short period after a sector erase request during which a parallel NOR flash still takes more sectors into the same erase. It does not decode bus unlock cycles. Its inputs are already-decoded command strobes: sector erase with a sector index, chip erase, erase suspend, and a catch-all for any other command. It also takes an erase-done indication from the erase engine. The length of the window is a run-time input counted in clock cycles. The nominal window is 50 µs, which is 5000 cycles at 100 MHz; the package carries that value as a constant.

Each accepted sector index sets its bit in a sector mask. Every new sector command restarts the full window. While the window is open, the status output reads 0. When the window runs out without a new command, the status goes to 1, a one-cycle start pulse is issued together with the mask, and from then on every command except erase suspend is ignored until the erase engine reports completion. A chip erase issued from idle skips the window entirely and starts at once with every sector selected.

Top module: `erase_win_top`

## Requirements
- R1: After reset, `erase_busy`, `window_open`, `erase_start`, `chip_mode` and `suspend_req` are 0, and `erase_mask` is all zeros.
- R2: A sector erase strobe in idle opens the window on the next cycle. `window_open` is 1, `erase_busy` is 0, and `erase_mask` holds only bit `sector_index` (index i maps to mask bit i).
- R3: With a timeout of T, `erase_busy` rises exactly T clock edges after the edge that sampled the last accepted sector command. `erase_start` is 1 for exactly that one cycle, and the mask is presented alongside it. A timeout of 0 behaves as 1.
- R4: A sector erase strobe while the window is open ORs its bit into the mask and restarts the full T-cycle window. This also applies when the strobe arrives on the very edge at which the window would have expired; the command wins over the expiry.
- R5: While `erase_busy` is 1, sector erase, chip erase and other commands are ignored. The mask, `chip_mode` and `erase_busy` are all unchanged, and no new `erase_start` is issued.
- R6: An erase suspend strobe while `erase_busy` is 1 gives a one-cycle `suspend_req` pulse on the next cycle. In idle or in the open window, a suspend has no effect.
- R7: `erase_done` while busy returns the block to idle on the next cycle, with `erase_busy` 0, `chip_mode` 0 and the mask all zeros.
- R8: A chip erase strobe in idle sets `erase_busy`, `erase_start` and `chip_mode` on the next cycle, with the mask all ones and no window.
- R9: A chip erase or other-command strobe while the window is open closes the window on the next cycle. The mask is cleared, `erase_busy` stays 0, and no `erase_start` follows.
- R10: In idle, other-command, suspend and erase_done strobes have no effect, and the internal window timer is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_cycles | input | CNT_W | Acceptance window length in clock cycles |
| sector_erase_cmd | input | 1 | Decoded sector erase strobe |
| sector_index | input | IDX_W | Sector selected by the sector erase strobe |
| chip_erase_cmd | input | 1 | Decoded chip erase strobe |
| suspend_cmd | input | 1 | Decoded erase suspend strobe |
| other_cmd | input | 1 | Any other decoded command |
| erase_done | input | 1 | Erase engine reports completion |
| erase_busy | output | 1 | Status: 0 while accepting sectors or idle, 1 once the erase has begun |
| window_open | output | 1 | Acceptance window currently running |
| erase_start | output | 1 | One-cycle pulse starting the erase |
| erase_mask | output | NUM_SECTORS | Selected sectors |
| chip_mode | output | 1 | Current erase is a whole-chip erase |
| suspend_req | output | 1 | One-cycle pulse forwarding an accepted suspend |

## Verification
The sharp case is a sector erase strobe landing on the same edge at which the window counter reaches its limit. Here restart and expiry fall in one cycle. The bench provokes this by waiting exactly T-1 cycles after a sector command and then issuing the next one. It judges the outcome by checking that `erase_busy` stays 0, that both sector bits are present in the mask, and that the erase then starts a full T cycles later rather than at once. A second coincidence checked directly is an ignored command arriving while the erase is busy. For that case the bench confirms that the mask and status are unchanged on the following cycle.

// File: rtl/erase_win_pkg.sv
package erase_win_pkg;

    // Nominal acceptance window: 50 us at a 100 MHz clock.
    localparam int unsigned NOMINAL_WINDOW_CYCLES = 5000;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_BUSY   = 2'd2
    } win_state_e;

    typedef enum logic [2:0] {
        MASK_HOLD  = 3'd0,
        MASK_LOAD  = 3'd1,
        MASK_MERGE = 3'd2,
        MASK_ALL   = 3'd3,
        MASK_CLEAR = 3'd4
    } mask_op_e;

    typedef struct packed {
        logic sector;
        logic chip;
        logic suspend;
        logic other;
        logic done;
    } cmd_t;

    // Window has run its course once the next count would reach the limit.
    // A limit of zero therefore behaves as a limit of one.
    function automatic logic window_elapsed(input int unsigned count,
                                            input int unsigned limit);
        return (count + 1) >= limit;
    endfunction

endpackage

// File: rtl/erase_win_timer.sv
module erase_win_timer
    import erase_win_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             elapsed
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    assign elapsed = run && window_elapsed(32'(count), 32'(limit));

    // R10: a stopped timer does not drift
    a_r10_timer_still: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(count));

endmodule

// File: rtl/erase_win_mask.sv
module erase_win_mask
    import erase_win_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    parameter int IDX_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  mask_op_e               op,
    input  logic [IDX_W-1:0]       idx,
    output logic [NUM_SECTORS-1:0] mask
);

    logic [NUM_SECTORS-1:0] sel;

    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_dec
        assign sel[g] = (idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else begin
            case (op)
                MASK_LOAD:  mask <= sel;
                MASK_MERGE: mask <= mask | sel;
                MASK_ALL:   mask <= '1;
                MASK_CLEAR: mask <= '0;
                default:    mask <= mask;
            endcase
        end
    end

    // R4: a merge never drops an already selected sector
    a_r4_merge_keeps: assert property (@(posedge clk) disable iff (rst)
        (op == MASK_MERGE) |=> (($past(mask) & ~mask) == '0));

endmodule

// File: rtl/erase_win_fsm.sv
module erase_win_fsm
    import erase_win_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmd_t     cmd,
    input  logic     elapsed,
    output logic     tmr_run,
    output logic     tmr_clear,
    output mask_op_e mask_op,
    output logic     window_open,
    output logic     busy,
    output logic     start_pulse,
    output logic     chip_mode,
    output logic     suspend_pulse
);

    win_state_e state, state_nx;
    logic       start_d, chip_d, susp_d;

    assign tmr_run     = (state == ST_WINDOW);
    assign window_open = (state == ST_WINDOW);
    assign busy        = (state == ST_BUSY);

    always_comb begin
        state_nx  = state;
        mask_op   = MASK_HOLD;
        tmr_clear = 1'b1;
        start_d   = 1'b0;
        chip_d    = chip_mode;
        susp_d    = 1'b0;
        case (state)
            ST_IDLE: begin
                chip_d = 1'b0;
                if (cmd.sector) begin
                    state_nx = ST_WINDOW;
                    mask_op  = MASK_LOAD;
                end else if (cmd.chip) begin
                    state_nx = ST_BUSY;
                    mask_op  = MASK_ALL;
                    start_d  = 1'b1;
                    chip_d   = 1'b1;
                end
            end
            ST_WINDOW: begin
                tmr_clear = 1'b0;
                if (cmd.sector) begin
                    mask_op   = MASK_MERGE;
                    tmr_clear = 1'b1;
                end else if (cmd.chip || cmd.other) begin
                    state_nx  = ST_IDLE;
                    mask_op   = MASK_CLEAR;
                    tmr_clear = 1'b1;
                end else if (elapsed) begin
                    state_nx  = ST_BUSY;
                    start_d   = 1'b1;
                    chip_d    = 1'b0;
                    tmr_clear = 1'b1;
                end
            end
            ST_BUSY: begin
                if (cmd.done) begin
                    state_nx = ST_IDLE;
                    mask_op  = MASK_CLEAR;
                    chip_d   = 1'b0;
                end else if (cmd.suspend) begin
                    susp_d = 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                mask_op  = MASK_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            start_pulse   <= 1'b0;
            chip_mode     <= 1'b0;
            suspend_pulse <= 1'b0;
        end else begin
            state         <= state_nx;
            start_pulse   <= start_d;
            chip_mode     <= chip_d;
            suspend_pulse <= susp_d;
        end
    end

    // R5: only erase_done leaves the busy state
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd.done) |=> busy);

    // R6: a suspend request only follows a busy cycle
    a_r6_suspend_when_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(suspend_pulse) |-> $past(busy));

    // R9: an abort never starts an erase
    a_r9_abort_no_start: assert property (@(posedge clk) disable iff (rst)
        (window_open && !cmd.sector && (cmd.chip || cmd.other)) |=> (!start_pulse && !busy));

endmodule

// File: rtl/erase_win_top.sv
module erase_win_top
    import erase_win_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    parameter int CNT_W       = 16,
    parameter int IDX_W       = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W-1:0]       timeout_cycles,
    input  logic                   sector_erase_cmd,
    input  logic [IDX_W-1:0]       sector_index,
    input  logic                   chip_erase_cmd,
    input  logic                   suspend_cmd,
    input  logic                   other_cmd,
    input  logic                   erase_done,
    output logic                   erase_busy,
    output logic                   window_open,
    output logic                   erase_start,
    output logic [NUM_SECTORS-1:0] erase_mask,
    output logic                   chip_mode,
    output logic                   suspend_req
);

    cmd_t             cmd;
    logic             tmr_run, tmr_clear, tmr_elapsed;
    logic [CNT_W-1:0] tmr_count;
    mask_op_e         mask_op;

    assign cmd = '{sector:  sector_erase_cmd,
                   chip:    chip_erase_cmd,
                   suspend: suspend_cmd,
                   other:   other_cmd,
                   done:    erase_done};

    erase_win_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .elapsed       (tmr_elapsed),
        .tmr_run       (tmr_run),
        .tmr_clear     (tmr_clear),
        .mask_op       (mask_op),
        .window_open   (window_open),
        .busy          (erase_busy),
        .start_pulse   (erase_start),
        .chip_mode     (chip_mode),
        .suspend_pulse (suspend_req)
    );

    erase_win_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .clear   (tmr_clear),
        .limit   (timeout_cycles),
        .count   (tmr_count),
        .elapsed (tmr_elapsed)
    );

    erase_win_mask #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .op   (mask_op),
        .idx  (sector_index),
        .mask (erase_mask)
    );

    // R3: a command inside the window restarts the count from zero
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        (window_open && sector_erase_cmd) |=> (window_open && tmr_count == '0));

    // R3: start is a single-cycle pulse
    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    // R3: start coincides with the status bit going high
    a_r3_start_with_busy: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> (erase_busy && erase_mask != '0));

    // R5: the mask is frozen while the erase runs
    a_r5_mask_frozen: assert property (@(posedge clk) disable iff (rst)
        (erase_busy && !erase_done) |=> $stable(erase_mask));

    // R7: completion clears everything
    a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
        (erase_busy && erase_done) |=> (!erase_busy && erase_mask == '0 && !chip_mode));

    // R8: a chip erase start selects every sector
    a_r8_chip_all: assert property (@(posedge clk) disable iff (rst)
        (erase_start && chip_mode) |-> (&erase_mask));

    // R10: the timer rests at zero outside the window
    a_r10_idle_timer: assert property (@(posedge clk) disable iff (rst)
        !window_open |-> (tmr_count == '0));

endmodule

// File: tb/tb_erase_win_top.sv
module tb_erase_win_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 8;
    localparam int CW         = 16;
    localparam int IW         = 3;
    localparam int T          = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] timeout_cycles = CW'(T);
    logic          s_sec = 0, s_chip = 0, s_sus = 0, s_oth = 0, s_done = 0;
    logic [IW-1:0] s_idx = '0;
    logic          busy, wopen, start, chipm, sreq;
    logic [NS-1:0] mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    erase_win_top #(.NUM_SECTORS(NS), .CNT_W(CW)) dut (
        .clk              (clk),
        .rst              (rst),
        .timeout_cycles   (timeout_cycles),
        .sector_erase_cmd (s_sec),
        .sector_index     (s_idx),
        .chip_erase_cmd   (s_chip),
        .suspend_cmd      (s_sus),
        .other_cmd        (s_oth),
        .erase_done       (s_done),
        .erase_busy       (busy),
        .window_open      (wopen),
        .erase_start      (start),
        .erase_mask       (mask),
        .chip_mode        (chipm),
        .suspend_req      (sreq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one strobe for one clock edge, return at the following negedge.
    task automatic pulse(input logic se, input logic ch, input logic sp,
                         input logic ot, input logic dn, input logic [IW-1:0] ix);
        s_sec = se; s_chip = ch; s_sus = sp; s_oth = ot; s_done = dn; s_idx = ix;
        @(posedge clk);
        @(negedge clk);
        s_sec = 0; s_chip = 0; s_sus = 0; s_oth = 0; s_done = 0;
    endtask

    // Wait through n cycles expecting the window still open.
    task automatic wait_open(input int n, input string req);
        bit bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy !== 1'b0 || start !== 1'b0) bad = 1;
        end
        chk(req, "status held 0 inside window", 32'(bad), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "window_open", 32'(wopen), 0);
        chk("R1", "erase_start", 32'(start), 0);
        chk("R1", "mask", 32'(mask), 0);
        chk("R1", "chip_mode", 32'(chipm), 0);
        chk("R1", "suspend_req", 32'(sreq), 0);
    endtask

    task automatic t_single();
        pulse(1, 0, 0, 0, 0, 3'd2);
        chk("R2", "window_open", 32'(wopen), 1);
        chk("R2", "busy", 32'(busy), 0);
        chk("R2", "mask", 32'(mask), 32'h04);
        wait_open(T - 1, "R3");
        @(negedge clk);
        chk("R3", "busy at T", 32'(busy), 1);
        chk("R3", "start at T", 32'(start), 1);
        chk("R3", "mask at start", 32'(mask), 32'h04);
        @(negedge clk);
        chk("R3", "start single cycle", 32'(start), 0);
        pulse(0, 0, 0, 0, 1, '0);
        chk("R7", "busy after done", 32'(busy), 0);
        chk("R7", "mask after done", 32'(mask), 0);
    endtask

    task automatic t_merge();
        pulse(1, 0, 0, 0, 0, 3'd1);
        repeat (5) @(negedge clk);
        pulse(1, 0, 0, 0, 0, 3'd6);
        chk("R4", "merged mask", 32'(mask), 32'h42);
        wait_open(T - 1, "R4");
        @(negedge clk);
        chk("R4", "busy after restarted window", 32'(busy), 1);
        chk("R4", "start after restarted window", 32'(start), 1);
        pulse(0, 0, 0, 0, 1, '0);
    endtask

    task automatic t_collide();
        pulse(1, 0, 0, 0, 0, 3'd0);
        repeat (T - 1) @(negedge clk);
        pulse(1, 0, 0, 0, 0, 3'd3);
        chk("R4", "collision: busy stays 0", 32'(busy), 0);
        chk("R4", "collision: window open", 32'(wopen), 1);
        chk("R4", "collision: mask", 32'(mask), 32'h09);
        wait_open(T - 1, "R4");
        @(negedge clk);
        chk("R4", "collision: busy after full window", 32'(busy), 1);
    endtask

    task automatic t_busy_ignore();
        pulse(1, 0, 0, 0, 0, 3'd0);
        chk("R5", "sector ignored: mask", 32'(mask), 32'h09);
        pulse(0, 1, 0, 0, 0, '0);
        chk("R5", "chip ignored: mask", 32'(mask), 32'h09);
        chk("R5", "chip ignored: chip_mode", 32'(chipm), 0);
        pulse(0, 0, 0, 1, 0, '0);
        chk("R5", "other ignored: busy", 32'(busy), 1);
        chk("R5", "no new start", 32'(start), 0);
    endtask

    task automatic t_suspend();
        pulse(0, 0, 1, 0, 0, '0);
        chk("R6", "suspend_req pulse", 32'(sreq), 1);
        chk("R6", "busy during suspend", 32'(busy), 1);
        @(negedge clk);
        chk("R6", "suspend_req single cycle", 32'(sreq), 0);
        pulse(0, 0, 0, 0, 1, '0);
        chk("R7", "idle after done", 32'(busy), 0);
        pulse(0, 0, 1, 0, 0, '0);
        chk("R6", "suspend in idle ignored", 32'(sreq), 0);
        pulse(1, 0, 0, 0, 0, 3'd5);
        pulse(0, 0, 1, 0, 0, '0);
        chk("R6", "suspend in window ignored", 32'(sreq), 0);
        chk("R6", "window kept after suspend", 32'(wopen), 1);
        wait_open(T - 2, "R6");
        @(negedge clk);
        chk("R6", "window expires after suspend", 32'(busy), 1);
        pulse(0, 0, 0, 0, 1, '0);
    endtask

    task automatic t_chip();
        pulse(0, 1, 0, 0, 0, '0);
        chk("R8", "busy", 32'(busy), 1);
        chk("R8", "start", 32'(start), 1);
        chk("R8", "mask all ones", 32'(mask), 32'hFF);
        chk("R8", "chip_mode", 32'(chipm), 1);
        chk("R8", "no window", 32'(wopen), 0);
        pulse(0, 0, 0, 0, 1, '0);
        chk("R7", "chip_mode cleared", 32'(chipm), 0);
        chk("R7", "mask cleared", 32'(mask), 0);
    endtask

    task automatic t_abort();
        bit started = 0;
        pulse(1, 0, 0, 0, 0, 3'd4);
        repeat (3) @(negedge clk);
        pulse(0, 0, 0, 1, 0, '0);
        chk("R9", "other aborts window", 32'(wopen), 0);
        chk("R9", "mask cleared", 32'(mask), 0);
        for (int i = 0; i < T + 2; i++) begin
            @(negedge clk);
            if (start || busy) started = 1;
        end
        chk("R9", "no erase after abort", 32'(started), 0);
        pulse(1, 0, 0, 0, 0, 3'd4);
        pulse(0, 1, 0, 0, 0, '0);
        chk("R9", "chip aborts window", 32'(wopen), 0);
        chk("R9", "chip abort: busy 0", 32'(busy), 0);
        chk("R9", "chip abort: mask 0", 32'(mask), 0);
    endtask

    task automatic t_idle();
        pulse(0, 0, 0, 1, 0, '0);
        chk("R10", "other in idle: window", 32'(wopen), 0);
        pulse(0, 0, 0, 0, 1, '0);
        chk("R10", "done in idle: busy", 32'(busy), 0);
        chk("R10", "done in idle: mask", 32'(mask), 0);
    endtask

    task automatic t_zero_timeout();
        timeout_cycles = '0;
        pulse(1, 0, 0, 0, 0, 3'd7);
        chk("R3", "zero timeout: window first", 32'(wopen), 1);
        @(negedge clk);
        chk("R3", "zero timeout acts as one", 32'(busy), 1);
        chk("R3", "zero timeout mask", 32'(mask), 32'h80);
        pulse(0, 0, 0, 0, 1, '0);
        timeout_cycles = CW'(T);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_single();
        t_merge();
        t_collide();
        t_busy_ignore();
        t_suspend();
        t_chip();
        t_abort();
        t_zero_timeout();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule